// File: doc/BRIEF.md
# Store and Eviction Write Buffer

This block sits between a processor core and the system bus. It holds up to four entries, each a 64-bit address, a 64-bit doubleword and an 8-bit byte-enable mask. Uncached stores and write-through stores take one entry each. A dirty-line eviction from the data cache takes all four entries in one cycle, one doubleword per entry. Entries leave in arrival order through a valid/ready drain port, one per handshake, so the core keeps running while memory is updated.

The buffer reports its occupancy, which is also the minimum number of cycles until it is empty. A companion output turns that count into the stall cost of a writeback-invalidate cache operation. A hit on a dirty line costs three cycles plus the cycles needed to empty the buffer. A hit on a clean line and a miss cost nothing. A load-address probe raises a stall while any held entry covers the same doubleword, so a load cannot read memory that a pending write is about to change.

Top module: `wb_buffer`

## Requirements
- R1: While rst_ni is low, the buffer is empty: occupancy_o is 0, empty_o is 1, drn_valid_o is 0 and ld_stall_o is 0.
- R2: The request codes enq_kind_i = 0 (uncached store), 1 (write-through store) and 3 (spare, treated as a store) each take one entry. Such a request is ready whenever occupancy_o is below 4. When the buffer is full it is not ready, and it is ignored.
- R3: The request code enq_kind_i = 2 (line eviction) is ready only when occupancy_o is 0. It then fills all four entries. Entry i gets address (enq_addr_i with bits 4..0 cleared) + 8*i, data enq_line_i[64*i+63:64*i] and byte-enable 8'hFF. These entries drain for i = 0, 1, 2, 3 in that order.
- R4: drn_valid_o is high exactly when occupancy_o is nonzero. drn_addr_o, drn_data_o and drn_be_o show the oldest entry. Each cycle with drn_valid_o and drn_ready_i both high removes that entry.
- R5: occupancy_o counts the held entries and changes on the clock edge after a push or a pop. empty_o is high exactly when occupancy_o is 0.
- R6: While drn_valid_o is high and drn_ready_i is low, the next cycle shows the same head entry.
- R7: ld_stall_o is high in the same cycle that ld_valid_i is high and a held entry's address matches ld_addr_i in bits 63..3. Otherwise ld_stall_o is low.
- R8: When op_valid_i, op_hit_i and op_dirty_i are all high, op_penalty_o equals 3 + occupancy_o. In every other case op_penalty_o is 0.
- R9: A single-entry push accepted in the same cycle as a drain handshake leaves occupancy_o unchanged. Readiness uses the occupancy before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Request present |
| enq_kind_i | input | 2 | Request code: 0 uncached, 1 write-through, 2 line eviction, 3 spare store |
| enq_addr_i | input | 64 | Store address, or any address inside the evicted line |
| enq_data_i | input | 64 | Store doubleword |
| enq_be_i | input | 8 | Store byte enables |
| enq_line_i | input | 256 | Evicted line, doubleword i in bits 64*i+63..64*i |
| enq_ready_o | output | 1 | Request accepted this cycle if valid |
| drn_valid_o | output | 1 | Head entry available |
| drn_addr_o | output | 64 | Head address |
| drn_data_o | output | 64 | Head data |
| drn_be_o | output | 8 | Head byte enables |
| drn_ready_i | input | 1 | Bus takes head entry |
| empty_o | output | 1 | Nothing held |
| occupancy_o | output | 3 | Held entries, also the cycles to empty |
| ld_valid_i | input | 1 | Load address probe valid |
| ld_addr_i | input | 64 | Load address |
| ld_stall_o | output | 1 | Load must wait for a pending write |
| op_valid_i | input | 1 | Writeback-invalidate operation present |
| op_hit_i | input | 1 | Operation hits the cache |
| op_dirty_i | input | 1 | Hit line is dirty |
| op_penalty_o | output | 3 | Extra stall cycles for the operation |

## Verification
Each directed pattern isolates one behaviour. Filling with single stores while the bus is stalled tests the full boundary and shows that a held head stays put. An eviction offered to a non-empty buffer and then to an empty one shows that line writes need the whole buffer and land in doubleword order. A push made together with a drain separates pre-edge readiness from post-edge counting. Load probes that differ only in the low three bits, or in bit 3, show that hazards are matched per doubleword. A long mixed stream of all request codes, bus stalls and cache-operation outcomes is compared on every cycle against a queue model.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    WB_UNCACHED = 2'd0,
    WB_WTHRU    = 2'd1,
    WB_LINE     = 2'd2,
    WB_SPARE    = 2'd3
  } wb_kind_e;
endpackage

// File: rtl/wb_store.sv
// Circular entry store; DEPTH must be a power of two, a line fills every slot.
module wb_store #(
  parameter int unsigned AW    = 64,
  parameter int unsigned DW    = 64,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned BW   = DW / 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned OFS  = $clog2(BW)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_one_i,
  input  logic                        push_line_i,
  input  logic [AW-1:0]               in_addr_i,
  input  logic [DW-1:0]               in_data_i,
  input  logic [BW-1:0]               in_be_i,
  input  logic [DEPTH*DW-1:0]         in_line_i,
  input  logic                        pop_i,
  output logic [AW-1:0]               head_addr_o,
  output logic [DW-1:0]               head_data_o,
  output logic [BW-1:0]               head_be_o,
  output logic [CW-1:0]               count_o,
  output logic [DEPTH-1:0]            slot_valid_o,
  output logic [DEPTH-1:0][AW-1:0]    slot_addr_o
);
  localparam int unsigned LOFS = PW + OFS;

  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][BW-1:0] be_q;
  logic [DEPTH-1:0]         vld_q;
  logic [PW-1:0]            rd_q, wr_q;
  logic [CW-1:0]            cnt_q, push_n;

  logic [DEPTH-1:0][PW-1:0] line_slot;
  logic [DEPTH-1:0][AW-1:0] line_addr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    assign line_slot[g] = wr_q + PW'(g);
    assign line_addr[g] = {in_addr_i[AW-1:LOFS], PW'(g), {OFS{1'b0}}};
  end

  always_comb begin
    push_n = '0;
    if (push_one_i)       push_n = CW'(1);
    else if (push_line_i) push_n = CW'(DEPTH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
      vld_q  <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_i) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= rd_q + PW'(1);
      end
      if (push_one_i) begin
        addr_q[wr_q] <= in_addr_i;
        data_q[wr_q] <= in_data_i;
        be_q[wr_q]   <= in_be_i;
        vld_q[wr_q]  <= 1'b1;
        wr_q         <= wr_q + PW'(1);
      end else if (push_line_i) begin
        // buffer is empty here; write pointer wraps back to itself
        for (int i = 0; i < DEPTH; i++) begin
          addr_q[line_slot[i]] <= line_addr[i];
          data_q[line_slot[i]] <= in_line_i[i*DW +: DW];
          be_q[line_slot[i]]   <= {BW{1'b1}};
          vld_q[line_slot[i]]  <= 1'b1;
        end
      end
      cnt_q <= cnt_q + push_n - CW'(pop_i);
    end
  end

  assign head_addr_o  = addr_q[rd_q];
  assign head_data_o  = data_q[rd_q];
  assign head_be_o    = be_q[rd_q];
  assign count_o      = cnt_q;
  assign slot_valid_o = vld_q;
  assign slot_addr_o  = addr_q;
endmodule

// File: rtl/wb_hazard.sv
module wb_hazard #(
  parameter int unsigned AW    = 64,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned OFS   = 3
) (
  input  logic                     ld_valid_i,
  input  logic [AW-1:0]            ld_addr_i,
  input  logic [DEPTH-1:0]         slot_valid_i,
  input  logic [DEPTH-1:0][AW-1:0] slot_addr_i,
  output logic                     stall_o
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [AW-1:0] diff;
    assign diff     = slot_addr_i[g] ^ ld_addr_i;
    assign match[g] = slot_valid_i[g] && ((diff >> OFS) == '0);
  end

  assign stall_o = ld_valid_i && (|match);
endmodule

// File: rtl/wb_cost.sv
module wb_cost #(
  parameter int unsigned CW         = 3,
  parameter int unsigned PEN_W      = 3,
  parameter int unsigned DIRTY_BASE = 3
) (
  input  logic             op_valid_i,
  input  logic             op_hit_i,
  input  logic             op_dirty_i,
  input  logic [CW-1:0]    drain_cnt_i,
  output logic [PEN_W-1:0] penalty_o
);
  always_comb begin
    penalty_o = '0;
    if (op_valid_i && op_hit_i && op_dirty_i)
      penalty_o = PEN_W'(DIRTY_BASE) + PEN_W'(drain_cnt_i);
  end
endmodule

// File: rtl/wb_buffer.sv
module wb_buffer
  import wb_pkg::*;
#(
  parameter int unsigned AW         = 64,
  parameter int unsigned DW         = 64,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned DIRTY_BASE = 3
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       enq_valid_i,
  input  logic [1:0]                                 enq_kind_i,
  input  logic [AW-1:0]                              enq_addr_i,
  input  logic [DW-1:0]                              enq_data_i,
  input  logic [DW/8-1:0]                            enq_be_i,
  input  logic [DEPTH*DW-1:0]                        enq_line_i,
  output logic                                       enq_ready_o,
  output logic                                       drn_valid_o,
  output logic [AW-1:0]                              drn_addr_o,
  output logic [DW-1:0]                              drn_data_o,
  output logic [DW/8-1:0]                            drn_be_o,
  input  logic                                       drn_ready_i,
  output logic                                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0]                 occupancy_o,
  input  logic                                       ld_valid_i,
  input  logic [AW-1:0]                              ld_addr_i,
  output logic                                       ld_stall_o,
  input  logic                                       op_valid_i,
  input  logic                                       op_hit_i,
  input  logic                                       op_dirty_i,
  output logic [$clog2(DIRTY_BASE+DEPTH+1)-1:0]      op_penalty_o
);
  localparam int unsigned BW    = DW / 8;
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned PEN_W = $clog2(DIRTY_BASE + DEPTH + 1);
  localparam int unsigned OFS   = $clog2(BW);

  logic                     is_line, full, push_one, push_line, pop;
  logic [CW-1:0]            count;
  logic [DEPTH-1:0]         slot_valid;
  logic [DEPTH-1:0][AW-1:0] slot_addr;

  assign is_line   = (enq_kind_i == WB_LINE);
  assign empty_o   = (count == '0);
  assign full      = (count == CW'(DEPTH));
  // readiness from pre-edge count only; a same-cycle drain is not credited
  assign enq_ready_o = is_line ? empty_o : !full;
  assign push_one  = enq_valid_i && enq_ready_o && !is_line;
  assign push_line = enq_valid_i && enq_ready_o && is_line;
  assign drn_valid_o = !empty_o;
  assign pop       = drn_valid_o && drn_ready_i;
  assign occupancy_o = count;

  wb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_one_i   (push_one),
    .push_line_i  (push_line),
    .in_addr_i    (enq_addr_i),
    .in_data_i    (enq_data_i),
    .in_be_i      (enq_be_i),
    .in_line_i    (enq_line_i),
    .pop_i        (pop),
    .head_addr_o  (drn_addr_o),
    .head_data_o  (drn_data_o),
    .head_be_o    (drn_be_o),
    .count_o      (count),
    .slot_valid_o (slot_valid),
    .slot_addr_o  (slot_addr)
  );

  wb_hazard #(.AW(AW), .DEPTH(DEPTH), .OFS(OFS)) u_hazard (
    .ld_valid_i   (ld_valid_i),
    .ld_addr_i    (ld_addr_i),
    .slot_valid_i (slot_valid),
    .slot_addr_i  (slot_addr),
    .stall_o      (ld_stall_o)
  );

  wb_cost #(.CW(CW), .PEN_W(PEN_W), .DIRTY_BASE(DIRTY_BASE)) u_cost (
    .op_valid_i  (op_valid_i),
    .op_hit_i    (op_hit_i),
    .op_dirty_i  (op_dirty_i),
    .drain_cnt_i (count),
    .penalty_o   (op_penalty_o)
  );
endmodule

// File: rtl/wb_buffer_chk.sv
module wb_buffer_chk
  import wb_pkg::*;
#(
  parameter int unsigned AW         = 64,
  parameter int unsigned DW         = 64,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned DIRTY_BASE = 3
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic                                  enq_valid_i,
  input logic [1:0]                            enq_kind_i,
  input logic                                  enq_ready_o,
  input logic                                  drn_valid_o,
  input logic                                  drn_ready_i,
  input logic [AW-1:0]                         drn_addr_o,
  input logic [DW-1:0]                         drn_data_o,
  input logic                                  empty_o,
  input logic [$clog2(DEPTH+1)-1:0]            occupancy_o,
  input logic                                  ld_stall_o,
  input logic                                  op_valid_i,
  input logic                                  op_hit_i,
  input logic [$clog2(DIRTY_BASE+DEPTH+1)-1:0] op_penalty_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic acc, acc_line, acc_one, pop;
  assign acc      = enq_valid_i && enq_ready_o;
  assign acc_line = acc && (enq_kind_i == WB_LINE);
  assign acc_one  = acc && (enq_kind_i != WB_LINE);
  assign pop      = drn_valid_o && drn_ready_i;

  p_occ_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occupancy_o <= CW'(DEPTH));

  p_full_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occupancy_o == CW'(DEPTH)) |-> !enq_ready_o);

  p_line_fills_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_line |=> (occupancy_o == CW'(DEPTH)));

  p_pop_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !acc) |=> (occupancy_o == $past(occupancy_o) - CW'(1)));

  p_head_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drn_valid_o && !drn_ready_i) |=>
      (drn_valid_o && $stable(drn_addr_o) && $stable(drn_data_o)));

  p_idle_no_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !ld_stall_o);

  p_miss_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !op_hit_i) |-> (op_penalty_o == '0));

  p_swap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && acc_one) |=> (occupancy_o == $past(occupancy_o)));
endmodule

bind wb_buffer wb_buffer_chk #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .DIRTY_BASE(DIRTY_BASE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enq_valid_i  (enq_valid_i),
  .enq_kind_i   (enq_kind_i),
  .enq_ready_o  (enq_ready_o),
  .drn_valid_o  (drn_valid_o),
  .drn_ready_i  (drn_ready_i),
  .drn_addr_o   (drn_addr_o),
  .drn_data_o   (drn_data_o),
  .empty_o      (empty_o),
  .occupancy_o  (occupancy_o),
  .ld_stall_o   (ld_stall_o),
  .op_valid_i   (op_valid_i),
  .op_hit_i     (op_hit_i),
  .op_penalty_o (op_penalty_o)
);

// File: tb/wb_buffer_bench.sv
`timescale 1ns/1ps
module wb_buffer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enq_valid = 1'b0;
  logic [1:0]   enq_kind = 2'd0;
  logic [63:0]  enq_addr = '0;
  logic [63:0]  enq_data = '0;
  logic [7:0]   enq_be = '0;
  logic [255:0] enq_line = '0;
  logic         enq_ready;
  logic         drn_valid;
  logic [63:0]  drn_addr, drn_data;
  logic [7:0]   drn_be;
  logic         drn_ready = 1'b0;
  logic         empty;
  logic [2:0]   occ;
  logic         ld_valid = 1'b0;
  logic [63:0]  ld_addr = '0;
  logic         ld_stall;
  logic         op_valid = 1'b0, op_hit = 1'b0, op_dirty = 1'b0;
  logic [2:0]   op_pen;

  always #2.5 clk = ~clk;

  wb_buffer u_wb_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_kind_i(enq_kind), .enq_addr_i(enq_addr),
    .enq_data_i(enq_data), .enq_be_i(enq_be), .enq_line_i(enq_line),
    .enq_ready_o(enq_ready),
    .drn_valid_o(drn_valid), .drn_addr_o(drn_addr), .drn_data_o(drn_data),
    .drn_be_o(drn_be), .drn_ready_i(drn_ready),
    .empty_o(empty), .occupancy_o(occ),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_stall_o(ld_stall),
    .op_valid_i(op_valid), .op_hit_i(op_hit), .op_dirty_i(op_dirty),
    .op_penalty_o(op_pen)
  );

  typedef struct {
    logic [63:0] a;
    logic [63:0] d;
    logic [7:0]  b;
  } ent_t;
  ent_t q[$];

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit prev_hold = 1'b0, prev_swap = 1'b0;
  logic [63:0] prev_addr, prev_data;
  int prev_occ;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    int sz;
    bit exp_rdy, exp_stall, do_pop, do_push;
    logic [63:0] exp_pen;
    ent_t e;
    #1;
    sz = q.size();
    exp_rdy = (enq_kind == 2'd2) ? (sz == 0) : (sz < 4);
    if (enq_kind == 2'd2) chk("R3", "enq_ready line", {63'd0, enq_ready}, {63'd0, exp_rdy});
    else                  chk("R2", "enq_ready store", {63'd0, enq_ready}, {63'd0, exp_rdy});
    chk("R5", "occupancy", {61'd0, occ}, 64'(sz));
    chk("R5", "empty", {63'd0, empty}, {63'd0, sz == 0});
    chk("R4", "drn_valid", {63'd0, drn_valid}, {63'd0, sz != 0});
    if (sz != 0) begin
      chk("R4", "head addr", drn_addr, q[0].a);
      chk("R4", "head data", drn_data, q[0].d);
      chk("R4", "head be", {56'd0, drn_be}, {56'd0, q[0].b});
    end
    exp_stall = 1'b0;
    for (int i = 0; i < sz; i++)
      if ((q[i].a >> 3) == (ld_addr >> 3)) exp_stall = ld_valid;
    chk("R7", "ld_stall", {63'd0, ld_stall}, {63'd0, exp_stall});
    exp_pen = (op_valid && op_hit && op_dirty) ? 64'(3 + sz) : 64'd0;
    chk("R8", "penalty", {61'd0, op_pen}, exp_pen);
    if (prev_hold) begin
      chk("R6", "held addr", drn_addr, prev_addr);
      chk("R6", "held data", drn_data, prev_data);
    end
    if (prev_swap) chk("R9", "occupancy after push+pop", {61'd0, occ}, 64'(prev_occ));
    do_pop  = (sz != 0) && drn_ready;
    do_push = enq_valid && exp_rdy;
    prev_hold = (sz != 0) && !drn_ready;
    prev_addr = drn_addr;
    prev_data = drn_data;
    prev_swap = do_pop && do_push && (enq_kind != 2'd2);
    prev_occ  = sz;
    @(posedge clk);
    if (do_pop) void'(q.pop_front());
    if (do_push) begin
      if (enq_kind == 2'd2) begin
        for (int i = 0; i < 4; i++) begin
          e.a = (enq_addr & ~64'h1F) + 64'(8 * i);
          e.d = enq_line[64*i +: 64];
          e.b = 8'hFF;
          q.push_back(e);
        end
      end else begin
        e.a = enq_addr; e.d = enq_data; e.b = enq_be;
        q.push_back(e);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    enq_valid = 0; drn_ready = 0; ld_valid = 0; op_valid = 0;
  endtask

  task automatic store(input logic [1:0] k, input logic [63:0] a, input logic [63:0] d);
    enq_valid = 1; enq_kind = k; enq_addr = a; enq_data = d; enq_be = 8'h0F;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, probes active
    @(negedge clk);
    ld_valid = 1; ld_addr = 64'h1000; op_valid = 1; op_hit = 1; op_dirty = 1;
    #1;
    chk("R1", "occupancy in reset", {61'd0, occ}, 64'd0);
    chk("R1", "empty in reset", {63'd0, empty}, 64'd1);
    chk("R1", "drn_valid in reset", {63'd0, drn_valid}, 64'd0);
    chk("R1", "ld_stall in reset", {63'd0, ld_stall}, 64'd0);
    @(negedge clk);
    rst_n = 1;
    idle_in();
    cyc();

    // fill with stores of every single-entry code, bus stalled (R2, R6)
    store(2'd0, 64'h1000, 64'hA0); cyc();
    store(2'd1, 64'h1008, 64'hA1); cyc();
    store(2'd3, 64'h1010, 64'hA2); cyc();
    store(2'd0, 64'h1018, 64'hA3); cyc();
    store(2'd1, 64'h2000, 64'hFF); cyc();               // full: ignored (R2)
    chk("R2", "full store ignored", {61'd0, occ}, 64'd4);
    enq_kind = 2'd2; enq_addr = 64'h3000; cyc();        // line into non-empty: ignored (R3)
    enq_valid = 0;

    // load hazards at doubleword granularity (R7)
    ld_valid = 1; ld_addr = 64'h1013; cyc();
    ld_addr = 64'h1020; cyc();
    ld_addr = 64'h1017; ld_valid = 0; cyc();
    // penalty cases (R8)
    op_valid = 1; op_hit = 1; op_dirty = 1; cyc();
    op_dirty = 0; cyc();
    op_hit = 0; op_dirty = 1; cyc();
    op_valid = 0;

    // drain with stall gaps, push alongside a pop (R4, R6, R9)
    drn_ready = 1; cyc();
    drn_ready = 0; cyc();
    drn_ready = 1; store(2'd1, 64'h1100, 64'hB0); cyc();
    enq_valid = 0; cyc();
    cyc(); cyc(); cyc(); cyc();
    drn_ready = 0;

    // line eviction into an empty buffer (R3)
    enq_valid = 1; enq_kind = 2'd2; enq_addr = 64'h4017;
    enq_line = {64'hD3, 64'hD2, 64'hD1, 64'hD0};
    cyc();
    enq_valid = 0;
    chk("R3", "line occupancy", {61'd0, occ}, 64'd4);
    chk("R3", "line word0 addr", drn_addr, 64'h4000);
    op_valid = 1; op_hit = 1; op_dirty = 1; cyc();
    op_valid = 0; ld_valid = 1; ld_addr = 64'h4018; cyc();
    ld_valid = 0; drn_ready = 1;
    repeat (5) cyc();
    op_valid = 1; cyc();                                // empty: penalty 3 (R8)
    op_valid = 0;

    // mixed stream against the model
    for (int n = 0; n < 400; n++) begin
      enq_valid = ($urandom % 3) != 0;
      enq_kind  = 2'($urandom % 4);
      enq_addr  = 64'h1000 + 64'(($urandom % 16) * 8) + 64'($urandom % 8);
      enq_data  = {$urandom, $urandom};
      enq_be    = 8'($urandom);
      enq_line  = {$urandom, $urandom, $urandom, $urandom,
                   $urandom, $urandom, $urandom, $urandom};
      drn_ready = ($urandom % 3) != 0;
      ld_valid  = ($urandom % 2) != 0;
      ld_addr   = 64'h1000 + 64'(($urandom % 16) * 8) + 64'($urandom % 8);
      op_valid  = ($urandom % 2) != 0;
      op_hit    = ($urandom % 2) != 0;
      op_dirty  = ($urandom % 2) != 0;
      cyc();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule